// File: doc/BRIEF.md
# Task-Driven Random Byte Generator

This peripheral produces one new 8-bit random value per generation period while it is active. Software starts and stops it with task writes on a simple 32-bit register port. Two hardware trigger inputs do the same through their rising edges, so other logic can drive it without a processor. When a period ends, the block loads the value register, raises a sticky ready flag and emits a one-cycle ready strobe. A one-shot option stops the generator after a single value. A filter option selects a longer period.

The ready flag drives a level interrupt through an enable bit. Software can write that bit directly or set and clear it through separate views. The value comes from a 16-bit maximal-length LFSR that advances on every clock. Period lengths are given in microseconds and converted to clock cycles from a clock-frequency parameter.

Top module: `rbg_periph`

## Requirements
- R1: Writing exactly 1 to offset 0x00 (start) makes the block active and reloads the countdown, also when it is already active. Writing exactly 1 to offset 0x04 (stop) makes it inactive and cancels the countdown. Any other value written to these offsets has no effect.
- R2: When a countdown ends, the low byte of the LFSR is loaded into the value register, readable at offset 0x20 in bits 7:0. The ready flag is set and `ready_pulse` is high for exactly one cycle. That cycle is P cycles after the clock edge that accepted the start. The LFSR uses x^16+x^14+x^13+x^11+1 (feedback = bits 15^13^12^10 shifted into bit 0, shifting left), has seed 0xACE1, and advances on every clock after reset release. The captured byte is its state before that edge.
- R3: With the one-shot bit (offset 0x0C, bit 0) set, the end of a countdown also makes the block inactive, so only one value is produced. With the bit clear, the countdown reloads and values repeat every P cycles.
- R4: P is CLK_HZ·RAW_US/10^6 cycles when the filter bit (offset 0x1C, bit 0) is 0, and CLK_HZ·FILT_US/10^6 cycles when it is 1. The defaults are 167 µs and 660 µs. The filter bit is sampled each time the countdown is loaded.
- R5: Writing 0 to offset 0x08 clears the ready flag. Writing any other value there leaves the flag unchanged. A read of 0x08 returns the flag in bit 0.
- R6: Bit 0 of offset 0x10 writes the interrupt enable directly. Offset 0x14 sets the enable only when bit 0 is 1. Offset 0x18 clears it only when bit 0 is 1. All three offsets read back the enable in bit 0.
- R7: `irq` is high exactly when the interrupt enable and the ready flag are both set.
- R8: A rising edge on `hw_start` acts as a start task, and a rising edge on `hw_stop` acts as a stop task. A held level does not repeat the task.
- R9: While `rst_n` is low, and after it rises, the value, active state, ready flag, one-shot bit, interrupt enable and filter bit are all 0, and `irq` and `ready_pulse` are low. Reset takes effect asynchronously. The release takes effect at the second rising clock edge after `rst_n` rises.
- R10: Reads of offsets not named above, including the task offsets, return 0. Writes to them change nothing. `bus_rdata` is 0 outside read cycles.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low reset, asynchronous assert |
| bus_valid | input | 1 | Register access this cycle |
| bus_write | input | 1 | 1 = write, 0 = read |
| bus_addr | input | ADDR_W | Byte offset of the access |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data, combinational in the read cycle |
| hw_start | input | 1 | Hardware start trigger, rising edge |
| hw_stop | input | 1 | Hardware stop trigger, rising edge |
| ready_pulse | output | 1 | One-cycle strobe per new value |
| irq | output | 1 | Level interrupt |

## Verification
The assertions check the following on every cycle:
- the strobe never lasts more than one cycle;
- no strobe follows an inactive cycle;
- the value register changes only together with the strobe;
- the ready flag and the interrupt follow the strobe;
- one-shot mode leaves the block inactive after its value.

The following can only be shown by the bench scenarios, which compare against a cycle-counting model and a model of the LFSR:
- exact period lengths in both filter modes;
- sampling of the filter bit at load time;
- countdown restart on a repeated start;
- rejection of non-trigger task values;
- edge-only hardware triggers;
- the three enable views;
- silent unmapped accesses.

// File: rtl/rbg_pkg.sv
package rbg_pkg;
  localparam int OFF_START = 'h00;
  localparam int OFF_STOP  = 'h04;
  localparam int OFF_READY = 'h08;
  localparam int OFF_ONESH = 'h0C;
  localparam int OFF_IE    = 'h10;
  localparam int OFF_IESET = 'h14;
  localparam int OFF_IECLR = 'h18;
  localparam int OFF_CFG   = 'h1C;
  localparam int OFF_VALUE = 'h20;

  localparam logic [31:0] TRIGGER = 32'd1;

  typedef struct packed {
    logic ready;
    logic one_shot;
    logic ie;
    logic slow;
  } rbg_ctrl_t;
endpackage

// File: rtl/rbg_lfsr.sv
module rbg_lfsr #(
  parameter int          W    = 16,
  parameter logic [W-1:0] TAPS = 16'hB400,
  parameter logic [W-1:0] SEED = 16'hACE1
) (
  input  logic         clk,
  input  logic         rst_n,
  output logic [W-1:0] state
);
  logic [W-1:0] state_d;
  logic         fb;

  always_comb begin
    fb      = ^(state & TAPS);
    state_d = {state[W-2:0], fb};
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) state <= SEED;
    else        state <= state_d;
  end
endmodule

// File: rtl/rbg_timer.sv
module rbg_timer #(
  parameter int P_RAW  = 167,
  parameter int P_FILT = 660,
  parameter int CNT_W  = 10
) (
  input  logic clk,
  input  logic rst_n,
  input  logic arm,
  input  logic halt,
  input  logic slow,
  input  logic one_shot,
  output logic active,
  output logic expire
);
  logic [CNT_W-1:0] cnt_q, cnt_d, load_val;
  logic             active_d, cnt_en;

  always_comb begin
    load_val = slow ? CNT_W'(P_FILT - 1) : CNT_W'(P_RAW - 1);
    expire   = active && (cnt_q == '0);
    active_d = active;
    cnt_d    = cnt_q;
    cnt_en   = 1'b0;
    if (arm) begin
      active_d = 1'b1;
      cnt_d    = load_val;
      cnt_en   = 1'b1;
    end else if (halt) begin
      active_d = 1'b0;
      cnt_d    = '0;
      cnt_en   = 1'b1;
    end else if (expire) begin
      active_d = !one_shot;
      cnt_d    = load_val;
      cnt_en   = 1'b1;
    end else if (active) begin
      cnt_d    = cnt_q - 1'b1;
      cnt_en   = 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      active <= 1'b0;
      cnt_q  <= '0;
    end else begin
      active <= active_d;
      if (cnt_en) cnt_q <= cnt_d;
    end
  end
endmodule

// File: rtl/rbg_regs.sv
module rbg_regs
  import rbg_pkg::*;
#(
  parameter int ADDR_W = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              bus_valid,
  input  logic              bus_write,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic [31:0]       bus_wdata,
  output logic [31:0]       bus_rdata,
  input  logic              hw_start_rise,
  input  logic              hw_stop_rise,
  input  logic              expire,
  input  logic [7:0]        rnd_byte,
  output logic              task_start,
  output logic              task_stop,
  output rbg_ctrl_t         ctrl_q,
  output logic [7:0]        value_q,
  output logic              ready_pulse,
  output logic              irq
);
  rbg_ctrl_t  ctrl_d;
  logic       wr, rd;
  logic       value_en;

  function automatic logic hit(input logic [ADDR_W-1:0] a, input int off);
    return a == ADDR_W'(off);
  endfunction

  always_comb begin
    wr         = bus_valid && bus_write;
    rd         = bus_valid && !bus_write;
    task_start = (wr && hit(bus_addr, OFF_START) && bus_wdata == TRIGGER) || hw_start_rise;
    task_stop  = (wr && hit(bus_addr, OFF_STOP)  && bus_wdata == TRIGGER) || hw_stop_rise;

    ctrl_d = ctrl_q;
    if (wr && hit(bus_addr, OFF_READY) && bus_wdata == 32'd0) ctrl_d.ready = 1'b0;
    if (expire) ctrl_d.ready = 1'b1;
    if (wr && hit(bus_addr, OFF_ONESH)) ctrl_d.one_shot = bus_wdata[0];
    if (wr && hit(bus_addr, OFF_IE))    ctrl_d.ie       = bus_wdata[0];
    if (wr && hit(bus_addr, OFF_IESET) && bus_wdata[0]) ctrl_d.ie = 1'b1;
    if (wr && hit(bus_addr, OFF_IECLR) && bus_wdata[0]) ctrl_d.ie = 1'b0;
    if (wr && hit(bus_addr, OFF_CFG))   ctrl_d.slow     = bus_wdata[0];

    value_en = expire;

    bus_rdata = '0;
    if (rd) begin
      if (hit(bus_addr, OFF_READY)) bus_rdata[0] = ctrl_q.ready;
      if (hit(bus_addr, OFF_ONESH)) bus_rdata[0] = ctrl_q.one_shot;
      if (hit(bus_addr, OFF_IE) || hit(bus_addr, OFF_IESET) || hit(bus_addr, OFF_IECLR))
        bus_rdata[0] = ctrl_q.ie;
      if (hit(bus_addr, OFF_CFG))   bus_rdata[0] = ctrl_q.slow;
      if (hit(bus_addr, OFF_VALUE)) bus_rdata[7:0] = value_q;
    end

    irq = ctrl_q.ie && ctrl_q.ready;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ctrl_q      <= '0;
      value_q     <= '0;
      ready_pulse <= 1'b0;
    end else begin
      ctrl_q      <= ctrl_d;
      ready_pulse <= expire;
      if (value_en) value_q <= rnd_byte;
    end
  end
endmodule

// File: rtl/rbg_periph.sv
module rbg_periph
  import rbg_pkg::*;
#(
  parameter int CLK_HZ  = 125_000_000,
  parameter int RAW_US  = 167,
  parameter int FILT_US = 660,
  parameter int ADDR_W  = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              bus_valid,
  input  logic              bus_write,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic [31:0]       bus_wdata,
  output logic [31:0]       bus_rdata,
  input  logic              hw_start,
  input  logic              hw_stop,
  output logic              ready_pulse,
  output logic              irq
);
  localparam longint RAW_L  = (longint'(CLK_HZ) * RAW_US)  / 1000000;
  localparam longint FILT_L = (longint'(CLK_HZ) * FILT_US) / 1000000;
  localparam int     P_RAW  = (RAW_L  < 2) ? 2 : int'(RAW_L);
  localparam int     P_FILT = (FILT_L < 2) ? 2 : int'(FILT_L);
  localparam int     P_MAX  = (P_RAW > P_FILT) ? P_RAW : P_FILT;
  localparam int     CNT_W  = $clog2(P_MAX + 1);

  logic [1:0]  rst_sync;
  logic        rst_s_n;
  logic        hw_start_q, hw_stop_q;
  logic        hw_start_rise, hw_stop_rise;
  logic        task_start, task_stop;
  logic        active, expire;
  logic [15:0] lfsr_state;
  logic [7:0]  value_q;
  rbg_ctrl_t   ctrl_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_sync <= 2'b00;
    else        rst_sync <= {rst_sync[0], 1'b1};
  end
  assign rst_s_n = rst_sync[1];

  always_ff @(posedge clk or negedge rst_s_n) begin
    if (!rst_s_n) begin
      hw_start_q <= 1'b0;
      hw_stop_q  <= 1'b0;
    end else begin
      hw_start_q <= hw_start;
      hw_stop_q  <= hw_stop;
    end
  end
  assign hw_start_rise = hw_start && !hw_start_q;
  assign hw_stop_rise  = hw_stop  && !hw_stop_q;

  rbg_lfsr #(.W(16), .TAPS(16'hB400), .SEED(16'hACE1)) u_lfsr (
    .clk   (clk),
    .rst_n (rst_s_n),
    .state (lfsr_state)
  );

  rbg_timer #(.P_RAW(P_RAW), .P_FILT(P_FILT), .CNT_W(CNT_W)) u_timer (
    .clk      (clk),
    .rst_n    (rst_s_n),
    .arm      (task_start),
    .halt     (task_stop),
    .slow     (ctrl_q.slow),
    .one_shot (ctrl_q.one_shot),
    .active   (active),
    .expire   (expire)
  );

  rbg_regs #(.ADDR_W(ADDR_W)) u_regs (
    .clk           (clk),
    .rst_n         (rst_s_n),
    .bus_valid     (bus_valid),
    .bus_write     (bus_write),
    .bus_addr      (bus_addr),
    .bus_wdata     (bus_wdata),
    .bus_rdata     (bus_rdata),
    .hw_start_rise (hw_start_rise),
    .hw_stop_rise  (hw_stop_rise),
    .expire        (expire),
    .rnd_byte      (lfsr_state[7:0]),
    .task_start    (task_start),
    .task_stop     (task_stop),
    .ctrl_q        (ctrl_q),
    .value_q       (value_q),
    .ready_pulse   (ready_pulse),
    .irq           (irq)
  );
endmodule

// File: rtl/rbg_periph_chk.sv
module rbg_periph_chk (
  input logic       clk,
  input logic       rst_s_n,
  input logic       ready_pulse,
  input logic       irq,
  input logic       active,
  input logic       task_start,
  input logic [7:0] value_q,
  input logic       ready_flag,
  input logic       ie,
  input logic       one_shot
);
  p_no_pulse_idle_r1: assert property (@(posedge clk) disable iff (!rst_s_n)
    !active |=> !ready_pulse);

  p_pulse_single_r2: assert property (@(posedge clk) disable iff (!rst_s_n)
    ready_pulse |=> !ready_pulse);

  p_value_hold_r2: assert property (@(posedge clk) disable iff (!rst_s_n)
    !ready_pulse |-> $stable(value_q));

  p_one_shot_stop_r3: assert property (@(posedge clk) disable iff (!rst_s_n)
    (ready_pulse && $past(one_shot) && !$past(task_start)) |-> !active);

  p_flag_on_pulse_r5: assert property (@(posedge clk) disable iff (!rst_s_n)
    ready_pulse |-> ready_flag);

  p_irq_needs_flag_r7: assert property (@(posedge clk) disable iff (!rst_s_n)
    irq |-> ready_flag);

  p_irq_on_pulse_r7: assert property (@(posedge clk) disable iff (!rst_s_n)
    (ready_pulse && ie) |-> irq);
endmodule

bind rbg_periph rbg_periph_chk u_chk (
  .clk         (clk),
  .rst_s_n     (rst_s_n),
  .ready_pulse (ready_pulse),
  .irq         (irq),
  .active      (active),
  .task_start  (task_start),
  .value_q     (value_q),
  .ready_flag  (ctrl_q.ready),
  .ie          (ctrl_q.ie),
  .one_shot    (ctrl_q.one_shot)
);

// File: tb/rbg_periph_tb.sv
`timescale 1ns/1ps
module rbg_periph_tb_top;
  localparam int CLK_HZ = 1_000_000;
  localparam int PR = 167;
  localparam int PF = 660;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        bus_valid = 1'b0, bus_write = 1'b0;
  logic [7:0]  bus_addr = '0;
  logic [31:0] bus_wdata = '0;
  logic [31:0] bus_rdata;
  logic        hw_start = 1'b0, hw_stop = 1'b0;
  logic        ready_pulse, irq;

  int checks = 0, errors = 0;
  int cyc = 0;
  logic [1:0]  rs;
  logic [15:0] m, mprev;

  always #4 clk = ~clk;

  rbg_periph #(.CLK_HZ(CLK_HZ), .RAW_US(167), .FILT_US(660), .ADDR_W(8)) dut_i (
    .clk(clk), .rst_n(rst_n), .bus_valid(bus_valid), .bus_write(bus_write),
    .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
    .hw_start(hw_start), .hw_stop(hw_stop), .ready_pulse(ready_pulse), .irq(irq)
  );

  function automatic logic [15:0] lfsr_step(input logic [15:0] s);
    return {s[14:0], s[15] ^ s[13] ^ s[12] ^ s[10]};
  endfunction

  always @(posedge clk) cyc <= cyc + 1;

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rs <= 2'b00; m <= 16'hACE1; mprev <= 16'hACE1;
    end else begin
      rs <= {rs[0], 1'b1};
      if (rs[1]) begin
        mprev <= m;
        m     <= lfsr_step(m);
      end
    end
  end

  task automatic chk(input string req, input longint act, input longint exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  int wr_cyc;
  task automatic bus_wr(input logic [7:0] a, input logic [31:0] d);
    @(negedge clk);
    bus_valid = 1'b1; bus_write = 1'b1; bus_addr = a; bus_wdata = d;
    @(negedge clk);
    bus_valid = 1'b0; bus_write = 1'b0;
    wr_cyc = cyc;
  endtask

  task automatic bus_rd(input logic [7:0] a, output logic [31:0] d);
    @(negedge clk);
    bus_valid = 1'b1; bus_write = 1'b0; bus_addr = a;
    #1 d = bus_rdata;
    bus_valid = 1'b0;
  endtask

  int   p_at;
  logic p_found;
  logic [7:0] p_exp;
  task automatic wait_pulse(input int maxc);
    p_found = 1'b0;
    for (int i = 0; i < maxc; i++) begin
      @(negedge clk);
      if (ready_pulse) begin
        p_found = 1'b1; p_at = cyc; p_exp = mprev[7:0];
        break;
      end
    end
  endtask

  task automatic idle(input int n);
    for (int i = 0; i < n; i++) @(negedge clk);
  endtask

  task automatic chk_value(input string req);
    logic [31:0] r;
    bus_rd(8'h20, r);
    chk(req, r, {24'd0, p_exp});
  endtask

  logic done = 1'b0;
  initial begin
    #(8 * 150000);
    if (!done) begin
      errors++;
      $display("FAIL watchdog: actual running expected finished");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    logic [31:0] r;
    int t0, prev;
    void'($urandom(32'd20240611));

    idle(3);
    rst_n = 1'b1;
    idle(3);
    // R9 reset state
    chk("R9 irq", irq, 0);
    chk("R9 pulse", ready_pulse, 0);
    bus_rd(8'h08, r); chk("R9 ready", r, 0);
    bus_rd(8'h0C, r); chk("R9 oneshot", r, 0);
    bus_rd(8'h10, r); chk("R9 ie", r, 0);
    bus_rd(8'h1C, r); chk("R9 cfg", r, 0);
    bus_rd(8'h20, r); chk("R9 value", r, 0);
    // R10 task offsets read as 0
    bus_rd(8'h00, r); chk("R10 start read", r, 0);

    // R1 non-trigger value ignored
    bus_wr(8'h00, 32'd2);
    wait_pulse(300); chk("R1 start value 2 ignored", p_found, 0);

    // R1 R2 R4 first value
    bus_wr(8'h00, 32'd1); t0 = wr_cyc;
    wait_pulse(PR + 5);
    chk("R2 pulse seen", p_found, 1);
    chk("R4 raw period", p_at - t0, PR);
    @(negedge clk); chk("R2 pulse one cycle", ready_pulse, 0);
    chk_value("R2 value");
    bus_rd(8'h08, r); chk("R5 ready read", r, 1);
    chk("R7 irq off while disabled", irq, 0);

    // R3 repeat
    prev = p_at;
    wait_pulse(PR + 5);
    chk("R3 repeat period", p_at - prev, PR);
    chk_value("R2 value repeat");

    // R6 enable views
    bus_wr(8'h14, 32'd0); bus_rd(8'h10, r); chk("R6 set with 0", r, 0);
    bus_wr(8'h14, 32'd1);
    bus_rd(8'h10, r); chk("R6 ie view", r, 1);
    bus_rd(8'h14, r); chk("R6 set view", r, 1);
    bus_rd(8'h18, r); chk("R6 clr view", r, 1);
    chk("R7 irq on", irq, 1);
    bus_wr(8'h18, 32'd0); bus_rd(8'h10, r); chk("R6 clr with 0", r, 1);
    bus_wr(8'h18, 32'd1); bus_rd(8'h10, r); chk("R6 clr", r, 0);
    chk("R7 irq off", irq, 0);
    bus_wr(8'h10, 32'd3); bus_rd(8'h18, r); chk("R6 direct 3", r, 1);
    bus_wr(8'h10, 32'd2); bus_rd(8'h14, r); chk("R6 direct 2", r, 0);
    bus_wr(8'h10, 32'd1);

    // R5 flag clear
    bus_wr(8'h08, 32'd1); bus_rd(8'h08, r); chk("R5 write 1 ignored", r, 1);
    bus_wr(8'h08, 32'd0); bus_rd(8'h08, r); chk("R5 cleared", r, 0);
    chk("R7 irq follows flag", irq, 0);

    // R1 stop
    bus_wr(8'h04, 32'd5);
    wait_pulse(PR + 5); chk("R1 stop value 5 ignored", p_found, 1);
    chk("R7 irq after value", irq, 1);
    bus_wr(8'h04, 32'd1);
    wait_pulse(400); chk("R1 stopped", p_found, 0);

    // R3 one-shot
    bus_wr(8'h08, 32'd0);
    bus_wr(8'h0C, 32'd1);
    bus_wr(8'h00, 32'd1); t0 = wr_cyc;
    wait_pulse(PR + 5); chk("R3 one-shot period", p_at - t0, PR);
    chk_value("R2 one-shot value");
    wait_pulse(400); chk("R3 single value", p_found, 0);
    bus_rd(8'h0C, r); chk("R3 bit readback", r, 1);

    // R4 filter
    bus_wr(8'h1C, 32'd1);
    bus_wr(8'h00, 32'd1); t0 = wr_cyc;
    wait_pulse(PF + 5); chk("R4 filtered period", p_at - t0, PF);
    bus_rd(8'h1C, r); chk("R4 cfg readback", r, 1);
    // R4 sampled at load
    bus_wr(8'h0C, 32'd0);
    bus_wr(8'h1C, 32'd0);
    bus_wr(8'h00, 32'd1); t0 = wr_cyc;
    idle(50);
    bus_wr(8'h1C, 32'd1);
    wait_pulse(PR + 5); chk("R4 sampled at load", p_at - t0, PR);
    prev = p_at;
    wait_pulse(PF + 5); chk("R4 reload uses new cfg", p_at - prev, PF);
    bus_wr(8'h04, 32'd1);

    // R1 restart
    bus_wr(8'h1C, 32'd0);
    bus_wr(8'h00, 32'd1);
    idle(100);
    bus_wr(8'h00, 32'd1); t0 = wr_cyc;
    wait_pulse(PR + 120); chk("R1 restart countdown", p_at - t0, PR);
    bus_wr(8'h04, 32'd1);

    // R8 hardware triggers
    @(negedge clk); hw_start = 1'b1;
    @(negedge clk); t0 = cyc;
    wait_pulse(PR + 5); chk("R8 hw start", p_at - t0, PR);
    prev = p_at;
    wait_pulse(PR + 5); chk("R8 held level no retrigger", p_at - prev, PR);
    chk_value("R2 hw value");
    @(negedge clk); hw_stop = 1'b1;
    wait_pulse(400); chk("R8 hw stop", p_found, 0);
    hw_start = 1'b0; hw_stop = 1'b0;
    idle(3);

    // R10 unmapped
    bus_wr(8'h08, 32'd0);
    bus_wr(8'h24, 32'hFFFF_FFFF);
    bus_wr(8'h0E, 32'd1);
    bus_wr(8'h1D, 32'd1);
    bus_wr(8'h40, 32'd1);
    bus_rd(8'h24, r); chk("R10 unmapped read", r, 0);
    bus_rd(8'h0C, r); chk("R10 oneshot untouched", r, 0);
    bus_rd(8'h1C, r); chk("R10 cfg untouched", r, 0);
    bus_rd(8'h08, r); chk("R10 flag untouched", r, 0);
    wait_pulse(300); chk("R10 no start", p_found, 0);

    // random mode mix, R4 R2 R3
    for (int it = 0; it < 6; it++) begin
      logic s;
      logic o;
      s = 1'($urandom % 2);
      o = 1'($urandom % 2);
      bus_wr(8'h1C, {31'd0, s});
      bus_wr(8'h0C, {31'd0, o});
      bus_wr(8'h00, 32'd1); t0 = wr_cyc;
      wait_pulse(PF + 5);
      chk("R4 random period", p_at - t0, s ? PF : PR);
      chk_value("R2 random value");
      prev = p_at;
      wait_pulse((s ? PF : PR) + 5);
      chk("R3 random mode", p_found, !o);
      bus_wr(8'h04, 32'd1);
    end

    done = 1'b1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule